// File: doc/BRIEF.md
# Strobed FIFO with Half-Full Flag

This block is a single-clock first-in first-out buffer of 512 words, each 9 bits wide. Writers and readers do not present a valid/ready handshake. Each side has an active-low strobe pin instead. Both strobes are asynchronous to the system clock. Each one passes through a synchronizer, and the block acts only on the detected edges, so one strobe pulse moves at most one word.

A write is committed on the falling edge of the write strobe. A read has two steps. On the falling edge of the read strobe, the oldest word is put on the output. On the rising edge, that word is retired. Three active-low flags report the buffer state: empty, full and more-than-half-full. After power-up the block stays locked and accepts nothing until its active-low reset has been applied once.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is low and after it is released, empty_n is 0, full_n is 1, half_n is 1 and data_out is 0. Both pointers return to the first location, so the first word written after reset is the first word read.
- R2: Before the first reset after power-up, write and read strobes have no effect. empty_n stays 0, full_n stays 1 and half_n stays 1.
- R3: Each falling edge of wr_strobe_n stores data_in once, in the next sequential location. Words are read back in the order written.
- R4: full_n is 0 exactly when 512 words are held. A write strobe while full_n is 0 stores nothing.
- R5: full_n returns to 1 on the rising edge of the read strobe of a valid read. It does not return on the falling edge.
- R6: half_n goes to 0 on the write that brings the occupancy from 256 to 257. It stays 1 while 256 or fewer words are held after writes.
- R7: half_n returns to 1 on the rising edge of the read strobe whose completion leaves 256 or fewer words.
- R8: empty_n is 0 exactly when no word is held. A read strobe while empty leaves data_out unchanged and moves no pointer.
- R9: data_out takes the oldest word on the falling edge of rd_strobe_n. The occupancy drops on the rising edge. A write strobe that arrives while a read strobe is held low keeps FIFO order.
- R10: A strobe level change made before clock edge k shows its effect on the flags and data after edge k+2, not earlier. This is two synchronizer stages plus one edge-detect register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; also unlocks writes after power-up |
| wr_strobe_n | input | 1 | Active-low write strobe, asynchronous |
| rd_strobe_n | input | 1 | Active-low read strobe, asynchronous |
| data_in | input | 9 | Write data, held stable around the write strobe falling edge |
| data_out | output | 9 | Read data, registered |
| empty_n | output | 1 | Low when the buffer holds no word |
| full_n | output | 1 | Low when the buffer holds 512 words |
| half_n | output | 1 | Low when more than half the buffer is occupied |

## Verification
Each kind of internal error shows up at the ports in its own way. A wrong occupancy count moves one of the three flags away from the reference queue size. A wrong pointer shows up as an out-of-order word on the next read's falling edge. A missed or doubled edge detection makes the count drift by one, and the next flag comparison catches it. All of these become visible three clock edges after the strobe change that caused them. The flag boundaries at 256/257 and 511/512 words, the read-while-empty case and the write-against-full case are driven on purpose. A full fill and drain then brings every wrong pointer out in the data.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

  // occupancy after an optional push and an optional pop
  function automatic int occ_next(int occ, logic push, logic pop);
    return occ + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // pointer advance with wrap for any depth
  function automatic int ptr_adv(int ptr, int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // half flag: set by a push that leaves more than half, cleared by a pop that leaves half or less
  function automatic logic half_next(logic cur, int occ_new, logic push, logic pop, int half);
    if (push && occ_new > half) return 1'b1;
    if (pop && occ_new <= half) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/strobe_fifo_edge.sv
module strobe_fifo_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain[0] <= strobe_n;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign fall = last & ~chain[STAGES-1];
  assign rise = ~last & chain[STAGES-1];

  AST_ONE_EDGE_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R3

endmodule

// File: rtl/strobe_fifo_store.sv
module strobe_fifo_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata)); // R8

endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fall,
  input  logic          rd_fall,
  input  logic          rd_rise,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  logic          armed = 1'b0;   // power-up lockout, released only by reset
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          hf, rd_pend;

  // named internal events
  logic is_full, is_empty, wr_acc, rd_start, rd_done;
  int   cnt_nxt;

  assign is_full  = (cnt == CW'(DEPTH));
  assign is_empty = (cnt == '0);
  assign wr_acc   = armed & wr_fall & ~is_full;
  assign rd_start = armed & rd_fall & ~is_empty & ~rd_pend;
  assign rd_done  = armed & rd_rise & rd_pend;
  assign cnt_nxt  = occ_next(int'(cnt), wr_acc, rd_done);

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      hf      <= 1'b0;
      rd_pend <= 1'b0;
    end else begin
      if (wr_acc)   wr_ptr <= AW'(ptr_adv(int'(wr_ptr), DEPTH));
      if (rd_done)  rd_ptr <= AW'(ptr_adv(int'(rd_ptr), DEPTH));
      if (rd_start) rd_pend <= 1'b1;
      else if (rd_done) rd_pend <= 1'b0;
      cnt <= CW'(cnt_nxt);
      hf  <= half_next(hf, cnt_nxt, wr_acc, rd_done, HALF);
    end
  end

  assign we      = wr_acc;
  assign waddr   = wr_ptr;
  assign re      = rd_start;
  assign raddr   = rd_ptr;
  assign empty_n = armed & ~is_empty;
  assign full_n  = ~(armed & is_full);
  assign half_n  = ~(armed & hf);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R4
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fall && is_full) |=> $stable(wr_ptr)); // R4
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> $stable(cnt)); // R2
  AST_HALF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hf) |-> cnt > CW'(HALF)); // R6
  AST_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hf) |-> cnt <= CW'(HALF)); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && is_empty && !rd_pend) |=> $stable(rd_ptr)); // R8

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int WIDTH       = 9,
  parameter int DEPTH       = 512,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_strobe_n,
  input  logic             rd_strobe_n,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  logic          wr_fall, wr_rise, rd_fall, rd_rise;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;

  strobe_fifo_edge #(.STAGES(SYNC_STAGES)) u_wr_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_strobe_n), .fall(wr_fall), .rise(wr_rise));

  strobe_fifo_edge #(.STAGES(SYNC_STAGES)) u_rd_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_strobe_n), .fall(rd_fall), .rise(rd_rise));

  strobe_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_fall(wr_fall), .rd_fall(rd_fall), .rd_rise(rd_rise),
    .we(we), .waddr(waddr), .re(re), .raddr(raddr),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n));

  strobe_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(data_in),
    .re(re), .raddr(raddr), .rdata(data_out));

  AST_WRITE_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |-> !we); // R3

endmodule

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;
  localparam int W = 9, D = 512, H = D / 2;

  logic clk = 1'b0, rst_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic empty_n, full_n, half_n;

  strobe_fifo dut_i (.clk(clk), .rst_n(rst_n), .wr_strobe_n(wr_n), .rd_strobe_n(rd_n),
    .data_in(din), .data_out(dout), .empty_n(empty_n), .full_n(full_n), .half_n(half_n));

  always #4 clk = ~clk;  // 125 MHz

  // reference model
  logic [W-1:0] q[$];
  bit  m_armed = 0, m_hf = 0, m_pend = 0;
  int  m_dout = 0;
  int  n_chk = 0, n_fail = 0, cyc = 0, last_mark = 0;
  bit  done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // compare every settled clock against the model
  always @(negedge clk) begin
    if (!done && rst_n && (cyc - last_mark >= 4)) begin
      chk("R8 empty_n", int'(empty_n), (m_armed && q.size() != 0) ? 1 : 0);
      chk("R4 full_n",  int'(full_n),  (m_armed && q.size() == D) ? 0 : 1);
      chk("R6 half_n",  int'(half_n),  (m_armed && m_hf) ? 0 : 1);
      if (m_armed) chk("R3 data_out", int'(dout), m_dout);
    end
  end

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_fall_drive(logic [W-1:0] d);
    din = d;
    @(negedge clk);
    wr_n = 1'b0; last_mark = cyc;
    if (m_armed && q.size() < D) begin
      q.push_back(d);
      if (q.size() > H) m_hf = 1;
    end
  endtask

  task automatic wr_rise_drive();
    @(negedge clk);
    wr_n = 1'b1; last_mark = cyc;
  endtask

  task automatic wr_word(logic [W-1:0] d);
    wr_fall_drive(d); settle(4); wr_rise_drive(); settle(4);
  endtask

  task automatic rd_fall_drive();
    @(negedge clk);
    rd_n = 1'b0; last_mark = cyc;
    if (m_armed && q.size() != 0 && !m_pend) begin
      m_dout = int'(q[0]); m_pend = 1;
    end
  endtask

  task automatic rd_rise_drive();
    @(negedge clk);
    rd_n = 1'b1; last_mark = cyc;
    if (m_pend) begin
      void'(q.pop_front()); m_pend = 0;
      if (q.size() <= H) m_hf = 0;
    end
  endtask

  task automatic rd_word();
    rd_fall_drive(); settle(4); rd_rise_drive(); settle(4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; last_mark = cyc;
    settle(3);
    chk("R1 empty_n in reset", int'(empty_n), 0);
    chk("R1 full_n in reset", int'(full_n), 1);
    chk("R1 half_n in reset", int'(half_n), 1);
    rst_n = 1'b1; last_mark = cyc;
    q.delete(); m_armed = 1; m_hf = 0; m_pend = 0; m_dout = 0;
    settle(4);
  endtask

  function automatic logic [W-1:0] pat(int i);
    return W'((i * 37 + 5) % 512);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int held;
    settle(6);
    // R2: strobes before any reset are ignored
    wr_word(9'h1AB);
    rd_word();
    settle(2);
    chk("R2 empty_n before reset", int'(empty_n), 0);
    chk("R2 full_n before reset", int'(full_n), 1);
    chk("R2 half_n before reset", int'(half_n), 1);

    do_reset();
    chk("R1 data_out after reset", int'(dout), 0);

    // R10: latency of a write strobe edge
    din = 9'h055;
    @(negedge clk);
    wr_n = 1'b0; last_mark = cyc; q.push_back(9'h055);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 no effect before edge k+2", int'(empty_n), 0);
    @(posedge clk); @(negedge clk);
    chk("R10 effect after edge k+2", int'(empty_n), 1);
    settle(3); wr_rise_drive(); settle(4);

    // R3: sequential order across a few words
    wr_word(9'h0F0); wr_word(9'h10F);
    rd_word(); chk("R3 first word", int'(dout), 9'h055);
    rd_word(); chk("R3 second word", int'(dout), 9'h0F0);
    // R9: data on falling edge, count on rising edge
    rd_fall_drive(); settle(4);
    chk("R9 data at read fall", int'(dout), 9'h10F);
    chk("R9 still not empty before rise", int'(empty_n), 1);
    rd_rise_drive(); settle(4);
    chk("R9 empty after rise", int'(empty_n), 0);

    // R8: read while empty holds output
    held = int'(dout);
    rd_word();
    chk("R8 data held on empty read", int'(dout), held);
    chk("R8 still empty", int'(empty_n), 0);

    // R6: half boundary
    for (int i = 0; i < H; i++) wr_word(pat(i));
    chk("R6 half_n high at 256", int'(half_n), 1);
    wr_word(pat(H));
    chk("R6 half_n low at 257", int'(half_n), 0);
    for (int i = H + 1; i < D; i++) wr_word(pat(i));
    chk("R4 full_n low at 512", int'(full_n), 0);
    wr_word(9'h1FF);
    chk("R4 refused write keeps full", int'(full_n), 0);

    // R5/R9: read held low, write attempt, then release
    rd_fall_drive(); settle(4);
    chk("R5 full stays low at read fall", int'(full_n), 0);
    chk("R9 oldest word at fall", int'(dout), int'(pat(0)));
    wr_fall_drive(9'h1EE); settle(4);
    rd_rise_drive(); settle(4);
    chk("R5 full_n high after read rise", int'(full_n), 1);
    wr_rise_drive(); settle(4);
    wr_word(9'h1EE);
    chk("R4 full again after refill", int'(full_n), 0);

    // R7: drain down through the half boundary
    for (int i = 0; i < D - H - 1; i++) rd_word();
    chk("R7 half_n low at 257", int'(half_n), 0);
    rd_word();
    chk("R7 half_n high at 256", int'(half_n), 1);
    while (q.size() != 0) rd_word();
    chk("R3 last word is the late write", int'(dout), 9'h1EE);
    chk("R8 empty after drain", int'(empty_n), 0);

    // R1: reset mid-stream returns pointers to start
    for (int i = 0; i < 5; i++) wr_word(pat(100 + i));
    do_reset();
    chk("R1 empty after reset", int'(empty_n), 0);
    wr_word(9'h0AA);
    rd_word();
    chk("R1 first word after reset", int'(dout), 9'h0AA);

    settle(4);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule